// File: doc/BRIEF.md
# Serially Addressed Bit-Programmable I/O Port

This block is a serial slave that gives a host control of an 8-bit general-purpose I/O port. Each port pin is an input or an output according to its bit in a direction register. A data register drives the output pins. A read of the data register returns the live pin level for input pins and the register value for output pins. The host reaches the block through a four-wire serial link with a chip enable, a clock, a data-in line and a data-out line. Every access is a two-byte frame: a control byte, then a data byte.

The control byte carries an identity field. The block answers only when this field equals its two strap inputs, so four blocks can share one chip enable. The control byte also selects the target register, the transfer direction, a write mode (plain, set-by-mask or clear-by-mask) and one of four compare conditions. A comparator evaluates the selected condition on every clock. Its result is latched when chip enable falls and is shifted out during the control byte of that access, so the host gets compare status with every read or write.

The serial inputs are sampled in the system clock domain through synchronizers. The block accepts either clock idle level and takes the idle level at the start of each access. Data is sampled on the edge that returns the clock to idle, and driven on the edge that leaves idle.

Top module: `spio_port`

## Requirements
- R1: After synchronous reset, pin_oe is 0x00 (all inputs), pin_out is 0x00, miso_oe is low and the compare condition is "all equal".
- R2: pin_oe bit i equals direction register bit i (1 = output), and pin_out equals the data register.
- R3: The control byte is taken MSB first with the fields [7:6] identity, [5] register select (1 direction, 0 data), [4] read (1) or write (0), [3:2] write mode, [1:0] compare condition. In write mode 00 (11 behaves the same) the data byte replaces the selected register, and the change takes effect only once the 16th bit has been sampled.
- R4: In write mode 01, every 1 in the data byte sets the matching bit of the selected register, and other bits keep their value.
- R5: In write mode 10, every 1 in the data byte clears the matching bit of the selected register, and other bits keep their value.
- R6: In a read of the data register, the data byte on miso is (direction AND data) OR (NOT direction AND pin_in). In a read of the direction register it is the direction register. In both cases the value is taken when the control byte completes, and it is sent MSB first.
- R7: When the identity field differs from id_strap, no register or compare condition changes, and miso_oe is low for the data byte.
- R8: If cs_n rises before the 16th bit, the pending write is dropped. The bit counter restarts at every access.
- R9: The sck level when cs_n falls is taken as the idle level. Both idle levels work, with sampling on the return-to-idle edge.
- R10: miso_oe is low while cs_n is high. Bits leave on miso MSB first, one on each leave-idle sck edge.
- R11: The compare result is latched at the falling edge of cs_n and driven on miso for all eight control-byte bits.
- R12: Compare codes: 00 pins equal the data register, 01 any pin differs from it, 10 input pins equal the data register (output pins ignored), 11 pins differ from the pin value latched at the previous cs_n fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip enable |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso (high = drive) |
| id_strap | input | 2 | Strap levels matched against the identity field |
| pin_in | input | 8 | Sensed port pin levels |
| pin_out | output | 8 | Port output values |
| pin_oe | output | 8 | Per-pin output enable (1 = output) |

## Verification
The embedded assertions check on every cycle that the bit counter clears while chip enable is high, that the counter never passes the frame length, that the registers hold except on a write strobe, that set and clear masks change only the masked bits, and that miso is never enabled while chip enable is high. Only the bench scenarios can show the end-to-end protocol: field decoding of real serial frames in both clock polarities, the mixed read value built from pins and registers, the dropped write after an early abort, and an ignored frame with a foreign identity. They also show the compare flag under all four conditions, with the pin snapshot carried from one access to the next.

// File: rtl/spio_pkg.sv
// Package: shared widths, field encodings and the control byte layout
// for the serial I/O port. Assumes a byte-wide port and two-byte frames.
package spio_pkg;
    localparam int PORT_W     = 8;
    localparam int FRAME_BITS = 2 * PORT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int BIT_W      = $clog2(PORT_W);
    localparam int ID_W       = 2;
    localparam int NUM_CMP    = 4;

    typedef enum logic [1:0] {
        WM_PLAIN = 2'b00,
        WM_SET   = 2'b01,
        WM_CLEAR = 2'b10,
        WM_ALT   = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        CMP_EQ      = 2'b00,
        CMP_NE      = 2'b01,
        CMP_IN_EQ   = 2'b10,
        CMP_CHANGED = 2'b11
    } cmode_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            sel_dir;
        logic            rd;
        wmode_e          wmode;
        cmode_e          cmode;
    } ctrl_t;
endpackage

// File: rtl/spio_sync.sv
// Module: multi-stage synchronizer for asynchronous inputs.
// Assumes every bit is sampled independently; RST_VAL sets the reset level.
module spio_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spio_serial.sv
// Module: serial frame engine. Detects the start of an access, latches the
// clock idle level and compare flag, counts bits, decodes the control byte
// and issues one-cycle strobes. Assumes synchronized inputs and clock phase
// with sampling on the return-to-idle edge.
module spio_serial
    import spio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [ID_W-1:0]   id_strap,
    input  logic              flag_now,
    input  logic [PORT_W-1:0] rd_val,
    output logic              cs_fall,
    output ctrl_t             ctrl_q,
    output logic              cmd_stb,
    output logic              wr_stb,
    output logic [PORT_W-1:0] wr_byte,
    output logic              miso,
    output logic              miso_oe
);
    logic              sck_q, cs_q, cpol_q, flag_lat;
    logic              active, lead, trail, id_ok, in_data;
    logic [CNT_W-1:0]  cnt;
    logic [PORT_W-1:0] sh, shift_nx, rd_snap;
    logic [BIT_W-1:0]  rd_idx;
    ctrl_t             ctrl_nx;

    assign cs_fall  = cs_q && !cs_n_s;
    assign active   = !cs_n_s && !cs_q;
    assign lead     = active && (sck_s != sck_q) && (sck_q == cpol_q);
    assign trail    = active && (sck_s != sck_q) && (sck_s == cpol_q);
    assign shift_nx = {sh[PORT_W-2:0], mosi_s};
    assign ctrl_nx  = ctrl_t'(shift_nx);
    assign id_ok    = (ctrl_q.id == id_strap);
    assign in_data  = (cnt >= CNT_W'(PORT_W));
    assign rd_idx   = BIT_W'(PORT_W - 1) - cnt[BIT_W-1:0];

    // Track previous sck and cs levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // At access start latch the sck idle level and the compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_q   <= 1'b0;
            flag_lat <= 1'b0;
        end else if (cs_fall) begin
            cpol_q   <= sck_s;
            flag_lat <= flag_now;
        end
    end

    // Count and shift in bits on the return-to-idle edge; decode the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            ctrl_q  <= '0;
            cmd_stb <= 1'b0;
            wr_stb  <= 1'b0;
            wr_byte <= '0;
        end else begin
            cmd_stb <= 1'b0;
            wr_stb  <= 1'b0;
            if (cs_n_s) begin
                cnt <= '0;
            end else if (trail && cnt != CNT_W'(FRAME_BITS)) begin
                sh  <= shift_nx;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(PORT_W - 1)) begin
                    ctrl_q  <= ctrl_nx;
                    cmd_stb <= (ctrl_nx.id == id_strap);
                end
                if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                    wr_stb  <= id_ok && !ctrl_q.rd;
                    wr_byte <= shift_nx;
                end
            end
        end
    end

    // Capture the read value once the control byte is decoded.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_snap <= '0;
        else if (cmd_stb) rd_snap <= rd_val;
    end

    // Drive the next outgoing bit on the leave-idle edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            miso <= 1'b0;
        end else if (lead) begin
            if (!in_data)                                       miso <= flag_lat;
            else if (cnt < CNT_W'(FRAME_BITS) && id_ok && ctrl_q.rd) miso <= rd_snap[rd_idx];
            else                                                miso <= 1'b0;
        end
    end

    assign miso_oe = !cs_n_s && !(in_data && !id_ok);

    // R8: the bit counter is cleared whenever chip enable is high.
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (cnt == '0));

    // R3: the counter never passes the frame length.
    p_frame_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS));

    // R3: a frame yields at most one write strobe.
    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/spio_regs.sv
// Module: direction and data registers, masked write logic, read mux and
// the four-way comparator. Assumes strobes arrive one cycle wide with the
// decoded control byte already stable.
module spio_regs
    import spio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    input  ctrl_t             ctrl,
    input  logic              cmd_stb,
    input  logic              wr_stb,
    input  logic [PORT_W-1:0] wr_byte,
    input  logic              cs_fall,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] rd_val,
    output logic              flag_now
);
    logic [PORT_W-1:0]  pins_s, snap_q, tgt, wr_nx, mixed;
    cmode_e             cmp_sel;
    logic [NUM_CMP-1:0] hit;

    spio_sync #(.W(PORT_W), .STAGES(2), .RST_VAL('0)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_s)
    );

    assign mixed  = (dir_q & data_q) | (~dir_q & pins_s);
    assign rd_val = ctrl.sel_dir ? dir_q : mixed;
    assign tgt    = ctrl.sel_dir ? dir_q : data_q;

    // Apply the write mode to the selected register.
    always_comb begin
        unique case (ctrl.wmode)
            WM_SET:   wr_nx = tgt | wr_byte;
            WM_CLEAR: wr_nx = tgt & ~wr_byte;
            default:  wr_nx = wr_byte;
        endcase
    end

    // Commit a completed write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (wr_stb) begin
            if (ctrl.sel_dir) dir_q  <= wr_nx;
            else              data_q <= wr_nx;
        end
    end

    // Hold the compare condition chosen by the last accepted control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_sel <= CMP_EQ;
        else if (cmd_stb) cmp_sel <= ctrl.cmode;
    end

    // Keep the pin snapshot taken at each access start.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (cs_fall) snap_q <= pins_s;
    end

    // Evaluate every compare condition in parallel.
    generate
        for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
            if (c == int'(CMP_EQ)) begin : g_eq
                assign hit[c] = (pins_s == data_q);
            end else if (c == int'(CMP_NE)) begin : g_ne
                assign hit[c] = (pins_s != data_q);
            end else if (c == int'(CMP_IN_EQ)) begin : g_in
                assign hit[c] = (((pins_s ^ data_q) & ~dir_q) == '0);
            end else begin : g_chg
                assign hit[c] = (pins_s != snap_q);
            end
        end
    endgenerate

    // Register the selected compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_now <= 1'b0;
        else        flag_now <= hit[cmp_sel];
    end

    // R3: registers hold unless a write strobe arrives.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(data_q) && $stable(dir_q)));

    // R4: a set-mode data write only adds the masked bits.
    p_set_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ctrl.sel_dir && ctrl.wmode == WM_SET)
        |=> data_q == ($past(data_q) | $past(wr_byte)));

    // R5: a clear-mode data write only removes the masked bits.
    p_clear_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ctrl.sel_dir && ctrl.wmode == WM_CLEAR)
        |=> data_q == ($past(data_q) & ~$past(wr_byte)));
endmodule

// File: rtl/spio_port.sv
// Module: top of the serial bit-programmable I/O port. Synchronizes the
// serial inputs, connects the frame engine to the register bank and maps
// registers to the pads. Assumes id_strap is static.
module spio_port
    import spio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic [ID_W-1:0]   id_strap,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic              cs_n_s, sck_s, mosi_s;
    logic              cs_fall, cmd_stb, wr_stb, flag_now;
    logic [PORT_W-1:0] wr_byte, rd_val, dir_q, data_q;
    ctrl_t             ctrl_q;

    spio_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, mosi}),
        .q     ({cs_n_s, sck_s, mosi_s})
    );

    spio_serial u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .id_strap (id_strap),
        .flag_now (flag_now),
        .rd_val   (rd_val),
        .cs_fall  (cs_fall),
        .ctrl_q   (ctrl_q),
        .cmd_stb  (cmd_stb),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );

    spio_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .ctrl     (ctrl_q),
        .cmd_stb  (cmd_stb),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .cs_fall  (cs_fall),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .rd_val   (rd_val),
        .flag_now (flag_now)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    // R10: miso is never enabled while chip enable is high.
    p_miso_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !miso_oe);
endmodule

// File: tb/spio_port_tb_top.sv
`timescale 1ns/1ps
module spio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [1:0] strap = 2'b10;
    logic [7:0] ext = 8'h00;
    logic [7:0] pin_in, pin_out, pin_oe;
    logic       miso, miso_oe;

    typedef struct {
        logic [16:0] v;
        string       req;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int    total = 0;
    int    bad   = 0;

    // bench model state
    logic [7:0] m_dir = 8'h00, m_data = 8'h00, m_snap = 8'h00;
    logic [1:0] m_sel = 2'b00;

    always #2.5 clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    spio_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .id_strap (strap),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    function automatic logic [7:0] pins_m();
        return (m_dir & m_data) | (~m_dir & ext);
    endfunction

    function automatic logic flag_m();
        logic [7:0] p = pins_m();
        case (m_sel)
            2'b00:   return p == m_data;
            2'b01:   return p != m_data;
            2'b10:   return ((p ^ m_data) & ~m_dir) == 8'h00;
            default: return p != m_snap;
        endcase
    endfunction

    function automatic logic [7:0] mk(logic [1:0] id, logic dsel, logic rd,
                                      logic [1:0] wm, logic [1:0] cm);
        return {id, dsel, rd, wm, cm};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Driver: runs one access, pushes expected and observed frames.
    task automatic xfer(logic cpol, logic [7:0] c, logic [7:0] d, int nbits, string req);
        item_t      e, a;
        logic       f     = flag_m();
        logic       match = (c[7:6] == strap);
        logic [7:0] rdv   = c[5] ? m_dir : pins_m();
        logic [7:0] wv;
        m_snap = pins_m();
        e.v   = {match, {8{f}}, (match && c[4]) ? rdv : 8'h00};
        e.req = req;
        a.v   = '0;
        a.req = req;
        @(negedge clk);
        sck  = cpol;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck  = ~cpol;
            mosi = (i < 8) ? c[7-i] : d[15-i];
            repeat (8) @(negedge clk);
            a.v[15-i] = miso_oe ? miso : 1'b0;
            if (i == 12) a.v[16] = miso_oe;
            sck = cpol;
            repeat (8) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        if (nbits >= 8 && match) m_sel = c[1:0];
        if (nbits == 16 && match && !c[4]) begin
            wv = c[5] ? m_dir : m_data;
            case (c[3:2])
                2'b01:   wv = wv | d;
                2'b10:   wv = wv & ~d;
                default: wv = d;
            endcase
            if (c[5]) m_dir = wv;
            else      m_data = wv;
        end
        if (nbits == 16) begin
            exp_q.push_back(e);
            act_q.push_back(a);
        end
    endtask

    // Monitor: pops and compares frames as they complete.
    initial begin
        item_t a, e;
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                a = act_q.pop_front();
                e = exp_q.pop_front();
                total++;
                if (a.v !== e.v) begin
                    bad++;
                    $display("FAIL %s frame act=%05h exp=%05h", e.req, a.v, e.v);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 miso_oe", miso_oe, 0);
        // R3/R2 plain direction write, compare EQ (R11/R12)
        xfer(0, mk(2'b10, 1, 0, 2'b00, 2'b00), 8'h0F, 16, "R3/R11/R12");
        chk("R2 pin_oe", pin_oe, 8'h0F);
        chk("R10 idle miso_oe", miso_oe, 0);
        xfer(0, mk(2'b10, 0, 0, 2'b00, 2'b01), 8'hA5, 16, "R3/R12");
        chk("R3 pin_out plain", pin_out, 8'hA5);
        xfer(0, mk(2'b10, 0, 0, 2'b01, 2'b10), 8'h50, 16, "R4/R12");
        chk("R4 set mask", pin_out, 8'hF5);
        xfer(0, mk(2'b10, 0, 0, 2'b10, 2'b11), 8'h81, 16, "R5/R12");
        chk("R5 clear mask", pin_out, 8'h74);
        ext = 8'hC3;
        repeat (10) @(negedge clk);
        xfer(0, mk(2'b10, 0, 1, 2'b00, 2'b01), 8'h00, 16, "R6 data read/R10/R12");
        chk("R6 read left data", pin_out, 8'h74);
        xfer(1, mk(2'b10, 1, 1, 2'b00, 2'b10), 8'h00, 16, "R6 dir read/R9");
        ext = 8'hC4;
        repeat (10) @(negedge clk);
        xfer(1, mk(2'b10, 0, 1, 2'b00, 2'b00), 8'h00, 16, "R9/R12 in_eq");
        xfer(0, mk(2'b01, 0, 0, 2'b00, 2'b11), 8'hFF, 16, "R7 foreign id");
        chk("R7 data untouched", pin_out, 8'h74);
        xfer(0, mk(2'b10, 0, 0, 2'b00, 2'b11), 8'h00, 12, "R8 abort");
        chk("R8 abort dropped", pin_out, 8'h74);
        ext = 8'h35;
        repeat (10) @(negedge clk);
        xfer(1, mk(2'b10, 0, 0, 2'b00, 2'b11), 8'h3C, 16, "R8 restart/R9/R12 changed");
        chk("R8 restart write", pin_out, 8'h3C);
        xfer(1, mk(2'b10, 0, 1, 2'b00, 2'b01), 8'h00, 16, "R12 unchanged/R6");
        xfer(0, mk(2'b10, 1, 0, 2'b11, 2'b00), 8'hF0, 16, "R3 alt mode/R12");
        chk("R3 alt plain dir", pin_oe, 8'hF0);
        chk("R2 pin_out", pin_out, 8'h3C);
        xfer(0, mk(2'b10, 0, 1, 2'b00, 2'b00), 8'h00, 16, "R6/R11");
        chk("R10 final idle", miso_oe, 0);
        repeat (20) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule